// File: doc/BRIEF.md
# Sequential Block-Transfer Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that holds a small bank of byte-wide control registers. It has no register address pointer that a master can set. Every transfer walks the bank from register 0 upward. A fast system clock oversamples both bus lines. The block recognises START and STOP conditions and answers only to its own 7-bit device address. It pulls SDA low through an open-drain enable output and never drives SDA high.

A block write carries two leading bytes, a command byte and a length byte. The slave acknowledges both and discards them. Each later byte is stored into the next register. A block read first returns a fixed byte-count value and then the register contents in ascending order. The control register (index 6 by default) drives five output-enable lines and two drive-strength select lines. Its top bit reads back the level of an external strap pin.

Top module: `blkreg_slave`

## Requirements
- R1: The device address is 7'b1101001, so address byte 0xD2 selects a write and 0xD3 selects a read. Either byte is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and SDA stays released until the next START.
- R2: In a write, the two bytes after the address (command, then length) are acknowledged and discarded. The bytes after them are stored into registers 0, 1, 2 and upward. The control register takes effect on its outputs, with oe_ctl = bits 4:0 and drive_ctl = bits 6:5.
- R3: In a read, the first byte returned after the address acknowledge is the byte count 0x09. After it come register 0, 1, 2 and upward, each sent MSB first.
- R4: The slave acknowledges every byte it receives. In a read, a master NACK (SDA high in the ninth clock) ends the transfer, and SDA stays released until the next START or STOP.
- R5: After reset, oe_ctl is 5'b11111, drive_ctl is 2'b00, sda_pull is 0, and registers 0 to 5 hold 0x00.
- R6: Bit 7 of the control register always reads the current level of strap_in. The bit 7 of any byte written to the control register is ignored.
- R7: A START, including a repeated START inside a transfer, resets the byte pointer. The next write again discards its command and length bytes and stores from register 0. The next read again begins with the byte count.
- R8: A STOP returns the slave to idle with SDA released. SCL pulses that arrive without a new START draw no response.
- R9: Written bytes beyond the last register are acknowledged and leave every register unchanged. Reads beyond the last register return 0x00.
- R10: The slave starts pulling SDA low only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_in | input | 1 | External select level, mirrored in control bit 7 |
| oe_ctl | output | 5 | Output-enable controls, 1 enables |
| drive_ctl | output | 2 | Drive-strength selects |

## Verification
Some rules are checked by assertions on every cycle. SDA is only pulled low while SCL is low. A STOP releases SDA. The ignore state keeps SDA released. A START clears the bit counter and the byte pointer. Control-register writes land on the outputs, and out-of-range writes change nothing. Other behaviour needs whole bus transactions driven by the bench: the discarded command and length bytes, the byte-count byte that opens a read, the ascending register order, the strap mirror, the behaviour after a NACK or a wrong address, and the pointer restart on a repeated START.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;
   // Protocol engine phases
   typedef enum logic [2:0] {
      ST_IDLE,     // waiting for START
      ST_RX,       // shifting a byte in from the master
      ST_ACK_OUT,  // slave drives the acknowledge bit
      ST_TX,       // shifting a byte out to the master
      ST_ACK_IN,   // master drives the acknowledge bit
      ST_SKIP      // not addressed or NACKed: silent until START/STOP
   } eng_state_t;

   localparam int OE_W    = 5;
   localparam int DRV_W   = 2;
   localparam int CTRL_W  = OE_W + DRV_W;
   localparam logic [CTRL_W-1:0] CTRL_RST = {{DRV_W{1'b0}}, {OE_W{1'b1}}};
   localparam int LEAD_BYTES = 2;   // command + length bytes dropped on writes
endpackage

// File: rtl/blkreg_sync.sv
module blkreg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] prev;

   assign raw = {scl_in, sda_in};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else        ff <= {ff[STAGES-2:0], raw[g]};
      end
      assign synced[g] = ff[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   assign scl_q     = synced[1];
   assign sda_q     = synced[0];
   assign scl_rise  = synced[1] & ~prev[1];
   assign scl_fall  = ~synced[1] & prev[1];
   assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
   assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/blkreg_bank.sv
module blkreg_bank
   import blkreg_pkg::*;
#(
   parameter int          NUM_REGS = 7,
   parameter int          CTRL_IDX = 6,
   parameter int          PTR_W    = 8,
   parameter logic [7:0]  GP_RST   = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   input  logic             strap_in,
   output logic [OE_W-1:0]  oe_ctl,
   output logic [DRV_W-1:0] drive_ctl
);
   localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [NUM_REGS-1:0][7:0] view;   // read view of every register
   logic [CTRL_W-1:0]        ctrl_q;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == CTRL_IDX) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctrl_q <= CTRL_RST;
            else if (wr_en && wr_idx == PTR_W'(i))
               ctrl_q <= wr_data[CTRL_W-1:0];   // top bit is read-only
         end
         assign view[i] = {strap_in, ctrl_q};
      end else begin : g_plain
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= GP_RST;
            else if (wr_en && wr_idx == PTR_W'(i))
               q <= wr_data;
         end
         assign view[i] = q;
      end
   end

   always_comb begin
      if (rd_idx < PTR_W'(NUM_REGS)) rd_data = view[rd_idx[SEL_W-1:0]];
      else                           rd_data = 8'h00;
   end

   assign oe_ctl    = ctrl_q[OE_W-1:0];
   assign drive_ctl = ctrl_q[CTRL_W-1:OE_W];

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == PTR_W'(CTRL_IDX)) |=>
         ({drive_ctl, oe_ctl} == $past(wr_data[CTRL_W-1:0])));

   assert_beyond_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= PTR_W'(NUM_REGS)) |=> ($stable(ctrl_q) && $stable(view[0])));
endmodule

// File: rtl/blkreg_engine.sv
module blkreg_engine
   import blkreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h69,
   parameter logic [7:0] BYTE_COUNT = 8'h09,
   parameter int         PTR_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_q,
   input  logic             sda_q,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_pull
);
   localparam logic [PTR_W-1:0] PTR_MAX = '1;

   eng_state_t       st;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic             is_addr;
   logic             rw;
   logic             mst_ack;
   logic [PTR_W-1:0] bidx;
   logic [PTR_W-1:0] tx_ptr;
   logic [7:0]       tx_byte;

   function automatic logic [PTR_W-1:0] sat_inc(input logic [PTR_W-1:0] v);
      return (v == PTR_MAX) ? v : v + 1'b1;
   endfunction

   // byte 0 of a read is the count, byte k is register k-1
   assign tx_ptr  = (st == ST_ACK_IN) ? sat_inc(bidx) : bidx;
   assign rd_idx  = tx_ptr - 1'b1;
   assign tx_byte = (tx_ptr == '0) ? BYTE_COUNT : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         is_addr  <= 1'b0;
         rw       <= 1'b0;
         mst_ack  <= 1'b0;
         bidx     <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st       <= ST_RX;
            bitcnt   <= '0;
            bidx     <= '0;
            is_addr  <= 1'b1;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_q};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (is_addr) begin
                        is_addr <= 1'b0;
                        if (shreg[7:1] == DEV_ADDR) begin
                           rw       <= shreg[0];
                           sda_pull <= 1'b1;
                           st       <= ST_ACK_OUT;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        st       <= ST_ACK_OUT;
                        bidx     <= sat_inc(bidx);
                        if (bidx >= PTR_W'(LEAD_BYTES)) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= bidx - PTR_W'(LEAD_BYTES);
                           wr_data <= shreg;
                        end
                     end
                  end
               end
               ST_ACK_OUT: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        st       <= ST_TX;
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                     end else begin
                        st       <= ST_RX;
                        sda_pull <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                        st       <= ST_ACK_IN;
                     end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_pull <= ~shreg[6];
                     end
                  end
               end
               ST_ACK_IN: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_q;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (mst_ack) begin
                        bidx     <= sat_inc(bidx);
                        st       <= ST_TX;
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;   // ST_IDLE, ST_SKIP wait for START
            endcase
         end
      end
   end

   assert_pull_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_q);

   assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !sda_pull);

   assert_start_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_RX && bitcnt == 4'd0 && bidx == '0 && !sda_pull));
endmodule

// File: rtl/blkreg_slave.sv
module blkreg_slave
   import blkreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter logic [7:0] BYTE_COUNT  = 8'h09,
   parameter int         NUM_REGS    = 7,
   parameter int         CTRL_IDX    = 6,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8,
   parameter logic [7:0] GP_RST      = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_pull,
   input  logic             strap_in,
   output logic [OE_W-1:0]  oe_ctl,
   output logic [DRV_W-1:0] drive_ctl
);
   if (CTRL_IDX < 0 || CTRL_IDX >= NUM_REGS) begin : g_bad_ctrl
      $error("blkreg_slave: CTRL_IDX must index an implemented register");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("blkreg_slave: SYNC_STAGES must be at least 2");
   end
   if (NUM_REGS >= (2 ** PTR_W) - 1) begin : g_bad_ptr
      $error("blkreg_slave: PTR_W too narrow for NUM_REGS");
   end

   logic             scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;

   blkreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   blkreg_engine #(.DEV_ADDR(DEV_ADDR), .BYTE_COUNT(BYTE_COUNT), .PTR_W(PTR_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_pull(sda_pull)
   );

   blkreg_bank #(.NUM_REGS(NUM_REGS), .CTRL_IDX(CTRL_IDX), .PTR_W(PTR_W), .GP_RST(GP_RST)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .strap_in(strap_in), .oe_ctl(oe_ctl), .drive_ctl(drive_ctl)
   );
endmodule

// File: tb/tb_blkreg_slave.sv
module tb_blkreg_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 20;          // system cycles per quarter SCL period

   typedef struct {
      logic [7:0] v;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       strap = 1'b0;
   logic       sda_pull;
   logic       sda_line;
   logic [4:0] oe_ctl;
   logic [1:0] drive_ctl;

   int checks = 0;
   int errors = 0;
   int r10_viol = 0;
   item_t      exp_q[$];
   logic [7:0] obs_q[$];

   assign sda_line = m_sda & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   blkreg_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .sda_pull(sda_pull), .strap_in(strap),
      .oe_ctl(oe_ctl), .drive_ctl(drive_ctl)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_item(input logic [7:0] v, input string req);
      exp_q.push_back('{v: v, req: req});
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_sda = 1'b0; wq(2*Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_sda = 1'b1; wq(2*Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wq(Q);
      m_scl = 1'b1; wq(2*Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      b = sda_line; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   // sends a byte, reports 1 if the slave acknowledged
   task automatic put_byte(input logic [7:0] d);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      obs_q.push_back({7'd0, ~a});
   endtask

   task automatic get_byte(input logic ack);
      logic [7:0] d;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      obs_q.push_back(d);
      send_bit(~ack);
   endtask

   // eight clocks with the master released, no acknowledge phase
   task automatic idle_byte();
      logic [7:0] d;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      obs_q.push_back(d);
   endtask

   // scoreboard monitor
   initial begin
      item_t e;
      logic [7:0] o;
      forever begin
         @(negedge clk);
         while (obs_q.size() != 0) begin
            o = obs_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL scoreboard: actual %0h expected nothing", o);
            end else begin
               e = exp_q.pop_front();
               if (o !== e.v) begin
                  errors++;
                  $display("FAIL %s: actual %0h expected %0h", e.req, o, e.v);
               end
            end
         end
      end
   end

   // R10 observer: a new pull-low must start while SCL is low
   initial begin
      logic prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && sda_pull && !prev && m_scl) r10_viol++;
         prev = sda_pull;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      report();
   end

   initial begin
      wq(5);
      // R5: reset values
      chk(32'(oe_ctl), 32'h1f, "R5 oe_ctl");
      chk(32'(drive_ctl), 32'h0, "R5 drive_ctl");
      chk(32'(sda_pull), 32'h0, "R5 sda_pull");
      rst_n = 1'b1;
      wq(10);
      chk(32'(oe_ctl), 32'h1f, "R5 oe_ctl after release");

      // block write, command and length dropped (R1 R2 R4 R9)
      bus_start();
      expect_item(8'h01, "R1 write address ack");   put_byte(8'hD2);
      expect_item(8'h01, "R2 command ack");         put_byte(8'hAA);
      expect_item(8'h01, "R2 length ack");          put_byte(8'h55);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h11);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h22);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h33);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h44);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h55);
      expect_item(8'h01, "R4 data ack");            put_byte(8'h66);
      expect_item(8'h01, "R4 control ack");         put_byte(8'hE5);
      expect_item(8'h01, "R9 beyond ack");          put_byte(8'h77);
      expect_item(8'h01, "R9 beyond ack");          put_byte(8'h88);
      bus_stop();
      chk(32'(oe_ctl), 32'h05, "R2 oe_ctl");
      chk(32'(drive_ctl), 32'h3, "R2 drive_ctl");

      // block read with strap low (R1 R3 R6 R9 R4)
      strap = 1'b0;
      bus_start();
      expect_item(8'h01, "R1 read address ack");    put_byte(8'hD3);
      expect_item(8'h09, "R3 byte count");          get_byte(1'b1);
      expect_item(8'h11, "R3 reg0");                get_byte(1'b1);
      expect_item(8'h22, "R3 reg1");                get_byte(1'b1);
      expect_item(8'h33, "R3 reg2");                get_byte(1'b1);
      expect_item(8'h44, "R3 reg3");                get_byte(1'b1);
      expect_item(8'h55, "R3 reg4");                get_byte(1'b1);
      expect_item(8'h66, "R3 reg5");                get_byte(1'b1);
      expect_item(8'h65, "R6 strap low, bit7 write ignored"); get_byte(1'b1);
      expect_item(8'h00, "R9 beyond read");         get_byte(1'b1);
      expect_item(8'h00, "R9 beyond read");         get_byte(1'b0);
      expect_item(8'hFF, "R4 released after NACK"); idle_byte();
      bus_stop();

      // strap high mirrors into bit 7 (R6)
      strap = 1'b1;
      wq(10);
      bus_start();
      expect_item(8'h01, "R1 read address ack");    put_byte(8'hD3);
      expect_item(8'h09, "R3 byte count");          get_byte(1'b1);
      for (int k = 0; k < 6; k++) begin
         expect_item(8'h11 * 8'(k + 1), "R3 reg walk");
         get_byte(1'b1);
      end
      expect_item(8'hE5, "R6 strap high");          get_byte(1'b0);
      bus_stop();

      // foreign address (R1)
      bus_start();
      expect_item(8'h00, "R1 foreign address NACK"); put_byte(8'hD4);
      expect_item(8'hFF, "R1 silent after mismatch"); idle_byte();
      bus_stop();
      chk(32'(oe_ctl), 32'h05, "R1 outputs untouched");

      // repeated START during a read (R7)
      bus_start();
      expect_item(8'h01, "R7 address ack");         put_byte(8'hD3);
      expect_item(8'h09, "R7 count");               get_byte(1'b1);
      expect_item(8'h11, "R7 reg0");                get_byte(1'b0);
      bus_start();
      expect_item(8'h01, "R7 address ack");         put_byte(8'hD3);
      expect_item(8'h09, "R7 count after restart"); get_byte(1'b1);
      expect_item(8'h11, "R7 reg0 after restart");  get_byte(1'b0);
      bus_stop();

      // repeated START during a write (R7)
      bus_start();
      expect_item(8'h01, "R7 address ack");         put_byte(8'hD2);
      expect_item(8'h01, "R7 command ack");         put_byte(8'h00);
      expect_item(8'h01, "R7 length ack");          put_byte(8'h00);
      expect_item(8'h01, "R7 data ack");            put_byte(8'h3C);
      bus_start();
      expect_item(8'h01, "R7 address ack");         put_byte(8'hD2);
      expect_item(8'h01, "R7 command ack");         put_byte(8'hC3);
      expect_item(8'h01, "R7 length ack");          put_byte(8'h99);
      expect_item(8'h01, "R7 data ack");            put_byte(8'h5A);
      bus_stop();
      bus_start();
      expect_item(8'h01, "R7 address ack");         put_byte(8'hD3);
      expect_item(8'h09, "R7 count");               get_byte(1'b1);
      expect_item(8'h5A, "R7 reg0 rewritten");      get_byte(1'b1);
      expect_item(8'h22, "R7 reg1 untouched");      get_byte(1'b0);
      bus_stop();

      // STOP mid-write returns to idle (R8)
      bus_start();
      expect_item(8'h01, "R8 address ack");         put_byte(8'hD2);
      expect_item(8'h01, "R8 command ack");         put_byte(8'h12);
      bus_stop();
      wq(5);
      chk(32'(sda_pull), 32'h0, "R8 released after STOP");
      m_scl = 1'b0; wq(Q);
      expect_item(8'hFF, "R8 no response while idle"); idle_byte();
      bus_stop();

      wq(20);
      chk(32'(r10_viol), 32'h0, "R10 pull starts with SCL low");
      chk(32'(exp_q.size()), 32'h0, "R3 scoreboard drained");
      report();
   end
endmodule